// File: doc/BRIEF.md
# PLL Power Mode Sequencer

This block chooses the operating power mode of a single PLL instance and drives the PLL's control pins to match. Software names a desired mode by writing a mode code; hardware condition inputs can also pull the PLL into a mode automatically and let it fall back when the condition clears. The sequencer powers the PLL up or down, selects whether the downstream clock comes from the PLL output or from the bypass path, and holds off the switch to the PLL output until the lock indicator has stayed high long enough.

Each instance is tuned by parameters: the mode it wakes up in after reset, a mask of the modes it supports, and whether gated interface clocks may automatically send it into low-power bypass. The current mode, including a transitional relocking state, is reported on a status output together with a sticky flag for rejected requests.

States (and status codes): OFF (0), LOCKED (1), LP_BYPASS (2), FR_BYPASS (3, fast-relock bypass), LP_STOP (4), MN_BYPASS (5), RELOCKING (6). Transitions: any state to OFF on device-off; any state to MN_BYPASS on global reset; any non-locked state to RELOCKING when the target is LOCKED; RELOCKING to LOCKED once lock has been qualified; LOCKED to RELOCKING on loss of lock; any state to the arbitrated target otherwise.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset the status shows the RESET_MODE parameter's code (default MN_BYPASS, 5) and the error flag is 0.
- R2: Outputs depend only on the status: out_clk_en is 0 only in OFF; out_lock_sel is 1 only in LOCKED; pll_en is 1 in LOCKED, RELOCKING and FR_BYPASS; pll_fast_relock is 1 only in FR_BYPASS.
- R3: A write of a supported code (0..5, mask bit set) becomes the software home mode at the next edge, and the status takes that mode one edge later when no higher-priority cause is active.
- R4: A write of a code that is 6, 7, or whose SUPPORT bit is clear is ignored (home mode unchanged) and sets req_err, which stays set until reset.
- R5: With auto_en high, dom_wake or pclk_req selects LOCKED as the target; with auto_en low these inputs have no effect.
- R6: With auto_en high, dom_idle or fclk_unused selects LP_STOP; when every automatic condition drops, the target returns to the software home mode.
- R7: With auto_en high and the AUTO_LPBYP parameter set, iclk_gated selects LP_BYPASS; among automatic causes LOCKED beats LP_STOP beats LP_BYPASS.
- R8: While glob_rst is high and MN_BYPASS is supported, the status goes to MN_BYPASS one edge later; the falling edge of glob_rst sets the home mode to LP_STOP if supported.
- R9: dev_off forces OFF one edge later, regardless of every other input.
- R10: Priority: dev_off, then glob_rst, then automatic conditions, then the software home mode.
- R11: Entering LOCKED passes through RELOCKING, which lasts until pll_lock has been high for lock_cycles consecutive edges (0 treated as 1); a low pll_lock restarts the count.
- R12: In LOCKED, a low pll_lock at an edge moves the status back to RELOCKING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_mode_wr | input | 1 | Software mode write strobe |
| sw_mode_code | input | 3 | Requested mode code |
| auto_en | input | 1 | Enables automatic transitions |
| dom_wake | input | 1 | Owning domain awake |
| dom_idle | input | 1 | Owning domain idle |
| pclk_req | input | 1 | At least one peripheral clock from the PLL requested |
| fclk_unused | input | 1 | All functional clocks from the PLL unused |
| iclk_gated | input | 1 | All interface clocks gated |
| glob_rst | input | 1 | Global reset asserted |
| dev_off | input | 1 | Device going off |
| pll_lock | input | 1 | Lock indicator from the PLL |
| lock_cycles | input | CNT_W | Consecutive lock cycles required |
| pll_en | output | 1 | PLL powered and running |
| pll_fast_relock | output | 1 | Keep PLL state for quick relock |
| out_clk_en | output | 1 | Output clock enabled |
| out_lock_sel | output | 1 | Output uses the locked frequency (else bypass) |
| mode_status | output | 3 | Current state code |
| req_err | output | 1 | Sticky rejected-request flag |

## Verification
The hardest situation to reach is a lock qualification that is interrupted: the status must sit in RELOCKING while pll_lock toggles, possibly while the target itself flips between LOCKED and another mode, and the count must restart each time. The stimulus reaches it by holding pll_lock high only most of the time under random input, varying lock_cycles between 0 and 3, and letting automatic wake and idle causes overlap with global reset and device-off pulses, all compared cycle by cycle with a bench model of the requirements; directed sequences first walk each transition once with fixed expected codes.

// File: rtl/pll_pwr_pkg.sv
package pll_pwr_pkg;

    typedef enum logic [2:0] {
        M_OFF    = 3'd0,
        M_LOCK   = 3'd1,
        M_LPBYP  = 3'd2,
        M_FRBYP  = 3'd3,
        M_LPSTOP = 3'd4,
        M_MNBYP  = 3'd5,
        M_RELOCK = 3'd6
    } mode_e;

    localparam int unsigned NUM_MODES = 6;

endpackage

// File: rtl/pps_req.sv
// Target arbitration: software home mode, automatic causes, forced causes.
module pps_req
    import pll_pwr_pkg::*;
#(
    parameter mode_e                  RESET_MODE = M_MNBYP,
    parameter logic [NUM_MODES-1:0]   SUPPORT    = '1,
    parameter bit                     AUTO_LPBYP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr,
    input  logic [2:0]  sw_code,
    input  logic        auto_en,
    input  logic        dom_wake,
    input  logic        pclk_req,
    input  logic        dom_idle,
    input  logic        fclk_unused,
    input  logic        iclk_gated,
    input  logic        glob_rst,
    input  logic        dev_off,
    output mode_e       target,
    output logic        err
);

    localparam logic [7:0] SUP8 = {2'b00, SUPPORT[NUM_MODES-1:1], 1'b1};

    mode_e home_q;
    logic  grst_q;
    logic  err_q;
    logic  code_ok;
    logic  grst_fall;

    assign code_ok   = SUP8[sw_code];
    assign grst_fall = grst_q && !glob_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            home_q <= RESET_MODE;
            grst_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            grst_q <= glob_rst;
            if (grst_fall && SUP8[M_LPSTOP]) begin
                home_q <= M_LPSTOP;
            end else if (sw_wr && code_ok) begin
                home_q <= mode_e'(sw_code);
            end
            if (sw_wr && !code_ok) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (dev_off) begin
            target = M_OFF;
        end else if (glob_rst && SUP8[M_MNBYP]) begin
            target = M_MNBYP;
        end else if (auto_en && (dom_wake || pclk_req) && SUP8[M_LOCK]) begin
            target = M_LOCK;
        end else if (auto_en && (dom_idle || fclk_unused) && SUP8[M_LPSTOP]) begin
            target = M_LPSTOP;
        end else if (auto_en && AUTO_LPBYP && iclk_gated && SUP8[M_LPBYP]) begin
            target = M_LPBYP;
        end else begin
            target = home_q;
        end
    end

    assign err = err_q;

    // R4: the error flag never clears once set
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R4: a rejected write raises the flag at the next edge
    p_bad_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !code_ok) |=> err_q);

    // R4: the home mode is always one the instance supports
    p_home_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        SUP8[home_q]);

    // R10: a forced cause always wins over software
    p_devoff_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_off |-> (target == M_OFF));

endmodule

// File: rtl/pps_lockwait.sv
// Counts consecutive lock-high cycles while relocking.
module pps_lockwait #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             lock,
    input  logic [CNT_W-1:0] thresh,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   thr_eff;

    assign thr_eff = (thresh == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, thresh};
    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign done    = run && lock && (cnt_inc >= thr_eff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !lock || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // R11: a low lock indicator always restarts the count
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !lock) |=> (cnt_q == '0));

    // R11: done only reported while lock is high
    p_done_needs_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lock);

endmodule

// File: rtl/pps_fsm.sv
// Mode state register and next-state selection.
module pps_fsm
    import pll_pwr_pkg::*;
#(
    parameter mode_e RESET_MODE = M_MNBYP
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e target,
    input  logic  pll_lock,
    input  logic  lock_done,
    output mode_e state
);

    mode_e state_q;
    mode_e state_d;

    function automatic mode_e enter(input mode_e tgt);
        return (tgt == M_LOCK) ? M_RELOCK : tgt;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_LOCK: begin
                if (target != M_LOCK) begin
                    state_d = target;
                end else if (!pll_lock) begin
                    state_d = M_RELOCK;
                end
            end
            M_RELOCK: begin
                if (target != M_LOCK) begin
                    state_d = target;
                end else if (lock_done) begin
                    state_d = M_LOCK;
                end
            end
            M_OFF:    state_d = enter(target);
            M_LPBYP:  state_d = enter(target);
            M_FRBYP:  state_d = enter(target);
            M_LPSTOP: state_d = enter(target);
            M_MNBYP:  state_d = enter(target);
            default:  state_d = RESET_MODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_MODE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R11: LOCKED is reached only through RELOCKING or by staying locked
    p_via_relock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_LOCK && state_q != M_RELOCK) |=> (state_q != M_LOCK));

    // R12: loss of lock while locked leaves LOCKED
    p_lock_loss_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_LOCK && !pll_lock) |=> (state_q != M_LOCK));

    // R9: device-off reaches OFF one edge later
    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (target == M_OFF) |=> (state_q == M_OFF));

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_pwr_pkg::*;
#(
    parameter mode_e                RESET_MODE = M_MNBYP,
    parameter logic [NUM_MODES-1:0] SUPPORT    = '1,
    parameter bit                   AUTO_LPBYP = 1'b1,
    parameter int unsigned          CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_mode_wr,
    input  logic [2:0]       sw_mode_code,
    input  logic             auto_en,
    input  logic             dom_wake,
    input  logic             dom_idle,
    input  logic             pclk_req,
    input  logic             fclk_unused,
    input  logic             iclk_gated,
    input  logic             glob_rst,
    input  logic             dev_off,
    input  logic             pll_lock,
    input  logic [CNT_W-1:0] lock_cycles,
    output logic             pll_en,
    output logic             pll_fast_relock,
    output logic             out_clk_en,
    output logic             out_lock_sel,
    output logic [2:0]       mode_status,
    output logic             req_err
);

    mode_e target;
    mode_e state;
    logic  lock_done;

    pps_req #(
        .RESET_MODE (RESET_MODE),
        .SUPPORT    (SUPPORT),
        .AUTO_LPBYP (AUTO_LPBYP)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr       (sw_mode_wr),
        .sw_code     (sw_mode_code),
        .auto_en     (auto_en),
        .dom_wake    (dom_wake),
        .pclk_req    (pclk_req),
        .dom_idle    (dom_idle),
        .fclk_unused (fclk_unused),
        .iclk_gated  (iclk_gated),
        .glob_rst    (glob_rst),
        .dev_off     (dev_off),
        .target      (target),
        .err         (req_err)
    );

    pps_lockwait #(
        .CNT_W (CNT_W)
    ) u_lockwait (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == M_RELOCK),
        .lock   (pll_lock),
        .thresh (lock_cycles),
        .done   (lock_done)
    );

    pps_fsm #(
        .RESET_MODE (RESET_MODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (target),
        .pll_lock  (pll_lock),
        .lock_done (lock_done),
        .state     (state)
    );

    always_comb begin
        pll_en          = 1'b0;
        pll_fast_relock = 1'b0;
        out_clk_en      = 1'b1;
        out_lock_sel    = 1'b0;
        unique case (state)
            M_OFF:    out_clk_en = 1'b0;
            M_LOCK: begin
                pll_en       = 1'b1;
                out_lock_sel = 1'b1;
            end
            M_RELOCK: pll_en = 1'b1;
            M_FRBYP: begin
                pll_en          = 1'b1;
                pll_fast_relock = 1'b1;
            end
            M_LPBYP:  pll_en = 1'b0;
            M_LPSTOP: pll_en = 1'b0;
            M_MNBYP:  pll_en = 1'b0;
            default:  out_clk_en = 1'b0;
        endcase
    end

    assign mode_status = state;

    // R2: the locked clock is never selected from an unpowered PLL
    p_sel_needs_pll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_lock_sel |-> (pll_en && out_clk_en));

    // R8: global reset forces MN bypass when device-off is absent
    p_grst_mn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_rst && !dev_off && SUPPORT[M_MNBYP]) |=> (mode_status == 3'd5));

    // R9: device-off turns the output clock off one edge later
    p_devoff_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_off |=> !out_clk_en);

endmodule

// File: tb/tb_pll_pwr_seq.sv
module tb_pll_pwr_seq;
    import pll_pwr_pkg::*;

    localparam logic [5:0] SUP = 6'b110111;   // fast-relock bypass unsupported
    localparam int unsigned CW = 8;
    localparam int RST_MODE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_mode_wr = 0;
    logic [2:0] sw_mode_code = 0;
    logic auto_en = 0, dom_wake = 0, dom_idle = 0, pclk_req = 0;
    logic fclk_unused = 0, iclk_gated = 0, glob_rst = 0, dev_off = 0;
    logic pll_lock = 0;
    logic [CW-1:0] lock_cycles = 3;
    logic pll_en, pll_fast_relock, out_clk_en, out_lock_sel, req_err;
    logic [2:0] mode_status;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pll_pwr_seq #(
        .RESET_MODE (M_MNBYP),
        .SUPPORT    (SUP),
        .AUTO_LPBYP (1'b1),
        .CNT_W      (CW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sw_mode_wr(sw_mode_wr), .sw_mode_code(sw_mode_code),
        .auto_en(auto_en), .dom_wake(dom_wake), .dom_idle(dom_idle), .pclk_req(pclk_req),
        .fclk_unused(fclk_unused), .iclk_gated(iclk_gated), .glob_rst(glob_rst),
        .dev_off(dev_off), .pll_lock(pll_lock), .lock_cycles(lock_cycles),
        .pll_en(pll_en), .pll_fast_relock(pll_fast_relock), .out_clk_en(out_clk_en),
        .out_lock_sel(out_lock_sel), .mode_status(mode_status), .req_err(req_err)
    );

    function automatic bit sup(input int c);
        return (c == 0) || (c < 6 && SUP[c]);
    endfunction

    function automatic int f_tgt(input int home);
        if (dev_off) return 0;
        if (glob_rst && sup(5)) return 5;
        if (auto_en && (dom_wake || pclk_req) && sup(1)) return 1;
        if (auto_en && (dom_idle || fclk_unused) && sup(4)) return 4;
        if (auto_en && iclk_gated && sup(2)) return 2;
        return home;
    endfunction

    // bench model of the requirements
    int m_home, m_st, m_cnt;
    bit m_err, m_g;

    always @(posedge clk) begin
        int t, thr;
        if (!rst_n) begin
            m_home <= RST_MODE; m_st <= RST_MODE; m_cnt <= 0; m_err <= 0; m_g <= 0;
        end else begin
            t   = f_tgt(m_home);
            thr = (lock_cycles == 0) ? 1 : int'(lock_cycles);
            m_g <= glob_rst;
            if (m_g && !glob_rst && sup(4)) m_home <= 4;
            else if (sw_mode_wr && sup(int'(sw_mode_code))) m_home <= int'(sw_mode_code);
            if (sw_mode_wr && !sup(int'(sw_mode_code))) m_err <= 1;
            if (t != 1) begin
                m_st <= t; m_cnt <= 0;
            end else if (m_st == 1) begin
                if (!pll_lock) m_st <= 6;
                m_cnt <= 0;
            end else if (m_st == 6) begin
                if (pll_lock) begin
                    if (m_cnt + 1 >= thr) begin m_st <= 1; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end else m_cnt <= 0;
            end else begin
                m_st <= 6; m_cnt <= 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag, input int s);
        chk({tag, " R2 status"}, int'(mode_status), s);
        chk({tag, " R2 out_clk_en"}, int'(out_clk_en), int'(s != 0));
        chk({tag, " R2 out_lock_sel"}, int'(out_lock_sel), int'(s == 1));
        chk({tag, " R2 pll_en"}, int'(pll_en), int'(s == 1 || s == 6 || s == 3));
        chk({tag, " R2 fast_relock"}, int'(pll_fast_relock), int'(s == 3));
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input int code);
        sw_mode_code = code[2:0];
        sw_mode_wr = 1;
        cyc(1);
        sw_mode_wr = 0;
    endtask

    bit done_flag = 0;

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 reset status", int'(mode_status), 5);
        chk("R1 reset err", int'(req_err), 0);
        chk_outs("R1", 5);

        // R3 manual write of LP bypass
        sw_write(2); cyc(1);
        chk("R3 manual LP bypass", int'(mode_status), 2);
        chk_outs("R3", 2);

        // R4 unsupported code 3 and invalid code 7
        sw_write(3); cyc(2);
        chk("R4 unsupported ignored", int'(mode_status), 2);
        chk("R4 sticky err", int'(req_err), 1);
        sw_write(7); sw_write(4); cyc(1);
        chk("R4 err stays set", int'(req_err), 1);
        chk("R3 write after error", int'(mode_status), 4);

        // R11 relock sequence, lock_cycles = 3
        sw_write(1); cyc(1);
        chk("R11 relocking", int'(mode_status), 6);
        chk_outs("R11", 6);
        cyc(3);
        chk("R11 held without lock", int'(mode_status), 6);
        pll_lock = 1;
        cyc(2);
        chk("R11 still relocking after 2", int'(mode_status), 6);
        cyc(1);
        chk("R11 locked after 3", int'(mode_status), 1);
        chk_outs("R11 locked", 1);

        // R12 loss of lock
        pll_lock = 0; cyc(1);
        chk("R12 lock loss", int'(mode_status), 6);
        pll_lock = 1; cyc(3);
        chk("R12 relocked", int'(mode_status), 1);

        // R6 automatic LP stop and return
        auto_en = 1; dom_idle = 1; cyc(1);
        chk("R6 auto LP stop", int'(mode_status), 4);
        dom_idle = 0; cyc(1);
        chk("R6 return to home", int'(mode_status), 6);
        cyc(3);
        chk("R6 home locked", int'(mode_status), 1);

        // R5 wake ignored without auto, then honoured
        auto_en = 0; sw_write(4); cyc(1);
        dom_wake = 1; cyc(2);
        chk("R5 wake ignored when auto off", int'(mode_status), 4);
        auto_en = 1; cyc(1);
        chk("R5 auto wake relocks", int'(mode_status), 6);
        dom_wake = 0; pclk_req = 1; cyc(3);
        chk("R5 pclk keeps locked", int'(mode_status), 1);
        pclk_req = 0; cyc(1);
        chk("R6 back to LP stop home", int'(mode_status), 4);

        // R7 interface clocks gated, R10 auto ordering
        sw_write(2); sw_write(5); cyc(1);
        iclk_gated = 1; cyc(1);
        chk("R7 auto LP bypass", int'(mode_status), 2);
        fclk_unused = 1; cyc(1);
        chk("R7 LP stop beats LP bypass", int'(mode_status), 4);
        fclk_unused = 0; iclk_gated = 0; cyc(1);
        chk("R6 return to MN home", int'(mode_status), 5);

        // R8 global reset with wake active, then release
        auto_en = 0; sw_write(2); cyc(1);
        auto_en = 1; dom_wake = 1; glob_rst = 1; cyc(1);
        chk("R10 global reset beats wake", int'(mode_status), 5);
        dom_wake = 0; auto_en = 0; cyc(1);
        glob_rst = 0; cyc(2);
        chk("R8 release goes to LP stop", int'(mode_status), 4);

        // R9 device-off beats everything
        glob_rst = 1; dev_off = 1; cyc(1);
        chk("R9 device off", int'(mode_status), 0);
        chk_outs("R9", 0);
        dev_off = 0; cyc(1);
        chk("R8 after device off", int'(mode_status), 5);
        glob_rst = 0; cyc(2);

        // constrained random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            sw_mode_wr   = ($urandom_range(0, 9) == 0);
            sw_mode_code = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 49) == 0) auto_en = ~auto_en;
            dom_wake    = ($urandom_range(0, 9) == 0);
            pclk_req    = ($urandom_range(0, 19) == 0);
            dom_idle    = ($urandom_range(0, 9) == 0);
            fclk_unused = ($urandom_range(0, 19) == 0);
            iclk_gated  = ($urandom_range(0, 7) == 0);
            glob_rst    = ($urandom_range(0, 49) == 0);
            dev_off     = ($urandom_range(0, 59) == 0);
            pll_lock    = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 99) == 0) lock_cycles = CW'($urandom_range(0, 3));
            cyc(1);
            chk_outs("R3 R5 R6 R7 R8 R9 R10 R11 R12 random", m_st);
            chk("R4 random err", int'(req_err), int'(m_err));
        end

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule